// File: doc/BRIEF.md
# Keypad Group Select Port

This block is the byte-wide keypad port of a handheld console. Software writes a pair of active-low group-select bits that choose which four buttons appear in the low nibble of the port. Reading returns those buttons active low: a pressed key reads 0. Either group can be shown alone, or both groups merged. When neither group is selected, the port reports the active controller number in place of keys.

The port re-evaluates the selected buttons on every clock, not only when software reads it. Whenever a visible bit changes from 1 to 0, the port sends a single-cycle interrupt request pulse to the interrupt controller. A write restarts the visible nibble from all-released, so a key that is already held counts as a new falling edge under the new selection. Debouncing and the interrupt controller are outside this block.

Top module: `keypad_port`

## Requirements
- R1: While reset is held and on the first cycle after it, `rd_data` is 8'hFF and `key_irq` is 0. Reset leaves the select bits at 2'b11 and the visible nibble at 4'hF.
- R2: A write keeps only `wr_data[5:4]` as the select field. Bits 7:6 of every value read back are 1, bits 5:4 read back the stored select field, and the other written bits have no effect.
- R3: With select 2'b10, the low nibble of the read value is the complement of `keys[7:4]`.
- R4: With select 2'b01, the low nibble is the complement of `keys[3:0]`.
- R5: With select 2'b00, the low nibble is the complement of `keys[7:4] | keys[3:0]`.
- R6: With select 2'b11, the low nibble is the complement of `ctrl_id`, whatever the keys are.
- R7: While `ctrl_id` is nonzero, `keys` is treated as 8'h00 (all released) for selects 2'b00, 2'b01 and 2'b10.
- R8: `key_irq` is 1 in the cycle after a clock edge where any bit of the newly computed visible nibble is 0 and the same bit was 1 in the previous visible nibble. A write makes the previous nibble count as 4'hF.
- R9: A key press in the selected group raises `key_irq` even if no read is made.
- R10: A key that is held steady gives only one `key_irq` pulse.
- R11: A read (`rd_en`) latches the value for that cycle, computed with any select written in the same cycle. `rd_data` shows this value from the next cycle and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe for the port |
| wr_data | input | 8 | Write byte; bits 5:4 are the select field |
| rd_en | input | 1 | Bus read strobe for the port |
| keys | input | 8 | Button state, 1 = pressed; [7:4] upper group, [3:0] lower group |
| ctrl_id | input | 4 | Active controller number |
| rd_data | output | 8 | Last value read from the port |
| key_irq | output | 1 | One-cycle keypad interrupt request |

## Verification
A corrupted select field appears in bits 5:4 of the very next read. The same fault also shows up as the wrong group in the low nibble, or as the complement of the controller number appearing where keys were expected. A stale or wrong stored visible nibble shows up as a missing interrupt, an extra interrupt, or a repeated interrupt on the clock after a key changes. The bench's reference model compares both outputs on every cycle, so any such fault is reported within one cycle of the stimulus that exposes it.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;
    localparam int SEL_LO = 4;

    typedef enum logic [1:0] {
        GSEL_BOTH = 2'b00,
        GSEL_LOW  = 2'b01,
        GSEL_HIGH = 2'b10,
        GSEL_NONE = 2'b11
    } grp_sel_e;

    typedef struct packed {
        logic [1:0]       top_ones;
        grp_sel_e         sel;
        logic [NIB_W-1:0] vis;
    } port_byte_t;

    function automatic port_byte_t pack_port(grp_sel_e s, logic [NIB_W-1:0] v);
        port_byte_t p;
        p.top_ones = 2'b11;
        p.sel      = s;
        p.vis      = v;
        return p;
    endfunction

endpackage

// File: rtl/keypad_sel_reg.sv
module keypad_sel_reg
    import keypad_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  logic [1:0] wr_sel,
    output grp_sel_e sel_q,
    output grp_sel_e sel_next
);
    always_comb begin
        sel_next = wr_en ? grp_sel_e'(wr_sel) : sel_q;
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= GSEL_NONE;
        else     sel_q <= sel_next;
    end
endmodule

// File: rtl/keypad_group_mux.sv
module keypad_group_mux
    import keypad_pkg::*;
#(
    parameter int KEY_W = 2 * keypad_pkg::NIB_W,
    parameter int ID_W  = keypad_pkg::NIB_W
) (
    input  grp_sel_e         sel,
    input  logic [KEY_W-1:0] keys,
    input  logic [ID_W-1:0]  ctrl_id,
    output logic [NIB_W-1:0] vis_n
);
    localparam int GRPS = KEY_W / NIB_W;

    logic [KEY_W-1:0] eff_keys;
    logic [NIB_W-1:0] grp [GRPS];
    logic [NIB_W-1:0] merged;
    logic [NIB_W-1:0] chosen;

    assign eff_keys = (ctrl_id != '0) ? '0 : keys;

    for (genvar g = 0; g < GRPS; g++) begin : g_split
        assign grp[g] = eff_keys[g*NIB_W +: NIB_W];
    end

    always_comb begin
        merged = '0;
        for (int g = 0; g < GRPS; g++) merged = merged | grp[g];
    end

    always_comb begin
        unique case (sel)
            GSEL_HIGH: chosen = grp[GRPS-1];
            GSEL_LOW:  chosen = grp[0];
            GSEL_BOTH: chosen = merged;
            default:   chosen = NIB_W'(ctrl_id);
        endcase
        vis_n = ~chosen;
    end
endmodule

// File: rtl/keypad_fall_det.sv
module keypad_fall_det
    import keypad_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [NIB_W-1:0] vis_n,
    output logic [NIB_W-1:0] nib_q,
    output logic             irq
);
    logic [NIB_W-1:0] prev;

    assign prev = wr_en ? '1 : nib_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nib_q <= '1;
            irq   <= 1'b0;
        end else begin
            nib_q <= vis_n;
            irq   <= |(prev & ~vis_n);
        end
    end
endmodule

// File: rtl/keypad_port.sv
module keypad_port
    import keypad_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    input  logic [KEY_W-1:0] keys,
    input  logic [ID_W-1:0]  ctrl_id,
    output logic [7:0]       rd_data,
    output logic             key_irq
);
    grp_sel_e         sel_q;
    grp_sel_e         sel_next;
    logic [NIB_W-1:0] vis_n;
    logic [NIB_W-1:0] nib_q;
    port_byte_t       rd_q;

    keypad_sel_reg u_sel (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_data[SEL_LO +: 2]),
        .sel_q    (sel_q),
        .sel_next (sel_next)
    );

    keypad_group_mux #(.KEY_W(KEY_W), .ID_W(ID_W)) u_mux (
        .sel     (sel_next),
        .keys    (keys),
        .ctrl_id (ctrl_id),
        .vis_n   (vis_n)
    );

    keypad_fall_det u_fall (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .vis_n (vis_n),
        .nib_q (nib_q),
        .irq   (key_irq)
    );

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= pack_port(GSEL_NONE, '1);
        else if (rd_en) rd_q <= pack_port(sel_next, vis_n);
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/keypad_port_chk.sv
module keypad_port_chk
    import keypad_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] keys,
    input logic [3:0] ctrl_id,
    input logic [7:0] rd_data,
    input logic       key_irq,
    input grp_sel_e   sel_q
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (rd_data == 8'hFF && !key_irq));

    assert_top_ones_R2: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:6] == 2'b11);

    assert_read_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    assert_high_group_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && sel_q == GSEL_HIGH && ctrl_id == 4'd0)
        |=> rd_data[3:0] == ~$past(keys[7:4]));

    assert_no_edge_no_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && !wr_en && !$past(wr_en)
         && $stable(keys) && $stable(ctrl_id)) |=> !key_irq);
endmodule

bind keypad_port keypad_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .keys    (keys),
    .ctrl_id (ctrl_id),
    .rd_data (rd_data),
    .key_irq (key_irq),
    .sel_q   (sel_q)
);

// File: tb/keypad_port_bench.sv
module keypad_port_bench;
    logic       clk = 0;
    logic       rst = 1;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic       rd_en = 0;
    logic [7:0] keys = 0;
    logic [3:0] ctrl_id = 0;
    logic [7:0] rd_data;
    logic       key_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R1";

    int m_sel = 3, m_nib = 15, m_irq = 0, m_rd = 255;

    always #5 clk = ~clk;

    keypad_port u_keypad_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .keys(keys), .ctrl_id(ctrl_id), .rd_data(rd_data), .key_irq(key_irq)
    );

    always @(posedge clk) begin
        int s, prev, k, g, nn;
        if (rst) begin
            m_sel = 3; m_nib = 15; m_irq = 0; m_rd = 255;
        end else begin
            s    = wr_en ? int'(wr_data[5:4]) : m_sel;
            prev = wr_en ? 15 : m_nib;
            k    = (ctrl_id != 0) ? 0 : int'(keys);
            case (s)
                2: g = (k >> 4) & 15;
                1: g = k & 15;
                0: g = (k | (k >> 4)) & 15;
                default: g = int'(ctrl_id);
            endcase
            nn    = (~g) & 15;
            m_irq = ((prev & ~nn & 15) != 0) ? 1 : 0;
            if (rd_en) m_rd = 192 | (s << 4) | nn;
            m_sel = s;
            m_nib = nn;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check({cur_req, " model rd_data"}, int'(rd_data), m_rd);
            check({cur_req, " model key_irq"}, int'(key_irq), m_irq);
        end
    end

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_en = 1; wr_data = v;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd_expect(string req, int exp);
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
        check(req, int'(rd_data), exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rd_data", int'(rd_data), 8'hFF);
        check("R1 reset irq", int'(key_irq), 0);
        rst = 0;
        @(negedge clk);
        check("R1 after reset rd_data", int'(rd_data), 8'hFF);

        cur_req = "R3"; keys = 8'h50; wr(8'h2A);
        rd_expect("R3/R2 upper group", 8'hEA);
        cur_req = "R4"; keys = 8'h0C; wr(8'h15);
        rd_expect("R4/R2 lower group", 8'hD3);
        cur_req = "R5"; keys = 8'h21; wr(8'hC0);
        rd_expect("R5 merged groups", 8'hCC);
        cur_req = "R6"; ctrl_id = 4'h5; keys = 8'hFF; wr(8'h30);
        rd_expect("R6 controller id", 8'hFA);
        cur_req = "R7"; ctrl_id = 4'h2; keys = 8'h0F; wr(8'h10);
        rd_expect("R7 keys released", 8'hDF);

        cur_req = "R9"; ctrl_id = 0; keys = 0; wr(8'h10); idle(3);
        check("R9 quiet before press", int'(key_irq), 0);
        keys = 8'h04;
        @(negedge clk);
        check("R9 irq on press", int'(key_irq), 1);
        cur_req = "R10";
        @(negedge clk);
        check("R10 single pulse", int'(key_irq), 0);
        idle(3);
        check("R10 held key quiet", int'(key_irq), 0);
        keys = 8'h40;
        @(negedge clk);
        check("R10 other group ignored", int'(key_irq), 0);

        cur_req = "R8"; keys = 8'h01; idle(2);
        @(negedge clk); wr_en = 1; wr_data = 8'h10;
        @(negedge clk); wr_en = 0;
        check("R8 write restarts nibble", int'(key_irq), 1);

        cur_req = "R11"; rd_expect("R11 read value", 8'hDE);
        keys = 8'h0F; idle(2);
        check("R11 rd_data holds", int'(rd_data), 8'hDE);
        @(negedge clk); rd_en = 1; wr_en = 1; wr_data = 8'h20;
        @(negedge clk); rd_en = 0; wr_en = 0;
        check("R11 read sees same-cycle write", int'(rd_data), 8'hEF);

        cur_req = "R1"; rst = 1; idle(2);
        check("R1 re-reset", int'(rd_data), 8'hFF);
        rst = 0; idle(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule